// File: doc/BRIEF.md
# Trap Commit and Delegation Unit

This unit takes one trap request per cycle and, one clock edge later, presents every architectural update that the trap requires. Each request carries a cause word, the program counter of the faulting instruction and an optional faulting address. The unit chooses one of four destinations: debug-mode entry for an enabled breakpoint, redirection to a fixed debug exception address while the hart is already in debug mode, a supervisor-level handler, or a machine-level handler.

The unit does not hold the architectural registers. It reads their current values from its inputs: privilege, status word, both delegation masks, both vector bases and the debug control fields. It returns registered data with one write strobe per destination register, which the surrounding register file applies. The unit also pulses a strobe that drops any outstanding load reservation.

Top module: `trap_commit`

## Requirements
- R1: A trap whose cause word equals the breakpoint code (3) enters debug mode when breakpoint-enable bit `i_ebreak_en[priv]` is set. Bit 0 is user, 1 supervisor, 2 the reserved level, 3 machine. Debug entry raises `o_dbg_we`, sets `o_dbg_cause` to 1 and `o_dbg_prv` to the current privilege, puts the trap PC on `o_epc`, writes privilege 3 and loads `o_pc` with `DBG_ROM_ADDR`. It raises no status, supervisor or machine strobe and does not clear the reservation.
- R2: A breakpoint whose enable bit for the current privilege is clear is handled as an ordinary trap, even when enable bits for other privileges are set.
- R3: When `i_dbg_cause` is non-zero, any trap that is not a debug-entry breakpoint only loads `o_pc` with `DBG_EXC_ADDR`. All other strobes stay low.
- R4: A debug-entry breakpoint takes precedence over the in-debug redirection of R3.
- R5: If cause bit XLEN-1 is set, the delegation bit comes from `i_mideleg` at the index formed by clearing that bit. Otherwise it comes from `i_medeleg` at the cause value.
- R6: A trap goes to supervisor only when the privilege is 0 or 1, the index is below XLEN and the selected delegation bit is 1. Every other trap goes to machine.
- R7: Supervisor entry raises `o_s_we`, loads `o_pc` with `i_stvec`, and drives the cause and trap PC on `o_cause` and `o_epc`. `o_s_bad_we` rises only when `i_bad_vld` is set.
- R8: Supervisor entry writes a status word in which bit 5 takes status bit [priv], bit 8 takes the privilege and bit 1 is cleared. All other bits are unchanged and privilege 1 is written.
- R9: Machine entry raises `o_m_we` and loads `o_pc` with `i_mtvec`. `o_m_bad_we` rises only when `i_bad_vld` is set. Bit 7 takes status bit [priv], bits 12:11 take the privilege, bit 3 is cleared and privilege 3 is written.
- R10: Every supervisor or machine entry pulses `o_resv_clr`.
- R11: After reset, every strobe is low.
- R12: All results appear on the first clock edge after the request and last for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| i_trap | input | 1 | Trap request, one cycle per trap |
| i_cause | input | XLEN | Cause word; MSB marks an interrupt |
| i_epc | input | XLEN | PC of the trapping instruction |
| i_bad | input | XLEN | Faulting address |
| i_bad_vld | input | 1 | Trap carries a faulting address |
| i_priv | input | 2 | Current privilege (0 U, 1 S, 2 reserved, 3 M) |
| i_status | input | XLEN | Current status word |
| i_medeleg | input | XLEN | Exception delegation mask |
| i_mideleg | input | XLEN | Interrupt delegation mask |
| i_stvec | input | XLEN | Supervisor handler base |
| i_mtvec | input | XLEN | Machine handler base |
| i_dbg_cause | input | 3 | Current debug cause; non-zero means in debug mode |
| i_ebreak_en | input | 4 | Breakpoint-to-debug enable per privilege |
| o_pc_we | output | 1 | Load next PC |
| o_pc | output | XLEN | Next PC |
| o_cause | output | XLEN | Cause for the target cause register |
| o_epc | output | XLEN | Trap PC for the exception-PC or debug-PC register |
| o_bad | output | XLEN | Faulting address for the target register |
| o_s_we | output | 1 | Write supervisor cause and exception PC |
| o_s_bad_we | output | 1 | Write supervisor faulting address |
| o_m_we | output | 1 | Write machine cause and exception PC |
| o_m_bad_we | output | 1 | Write machine faulting address |
| o_status_we | output | 1 | Write status word |
| o_status | output | XLEN | New status word |
| o_priv_we | output | 1 | Write privilege |
| o_priv | output | 2 | New privilege |
| o_dbg_we | output | 1 | Write debug cause, debug privilege and debug PC |
| o_dbg_cause | output | 3 | New debug cause |
| o_dbg_prv | output | 2 | Privilege recorded on debug entry |
| o_resv_clr | output | 1 | Clear load reservation |

## Verification
Debug-entry breakpoints and in-debug redirection can both apply to one request. The bench provokes this by issuing an enabled breakpoint while `i_dbg_cause` is non-zero, and it expects a full debug entry with the ROM start address rather than the exception address. Supervisor delegation and the index range check also overlap: an exception code of 40 with an all-ones delegation mask aliases bit 8 if the range check is missing. The bench requires that request to go to machine.

// File: rtl/trap_pkg.sv
// Shared types and status-word bit positions for the trap commit unit.
// Assumes the standard status layout: enables at 0/1/3, previous enables
// at 4/5/7, supervisor previous privilege at 8, machine at 12:11.
package trap_pkg;

    typedef enum logic [1:0] {
        PRV_U = 2'd0,
        PRV_S = 2'd1,
        PRV_H = 2'd2,
        PRV_M = 2'd3
    } priv_e;

    typedef enum logic [2:0] {
        DEST_NONE      = 3'd0,
        DEST_DBG_ENTER = 3'd1,
        DEST_DBG_REDIR = 3'd2,
        DEST_SUP       = 3'd3,
        DEST_MACH      = 3'd4
    } dest_e;

    localparam int ST_SIE    = 1;
    localparam int ST_MIE    = 3;
    localparam int ST_SPIE   = 5;
    localparam int ST_MPIE   = 7;
    localparam int ST_SPP    = 8;
    localparam int ST_MPP_LO = 11;
    localparam int ST_MPP_HI = 12;

    localparam logic [2:0] DBG_CAUSE_SWBP = 3'd1;

    // Privilege writes never land on the reserved level
    function automatic priv_e legal_priv(priv_e p);
        return (p == PRV_H) ? PRV_U : p;
    endfunction

endpackage

// File: rtl/trap_route.sv
// Chooses where a trap goes: debug entry, debug redirect, supervisor or
// machine. Purely combinational; assumes XLEN is a power of two >= 8.
module trap_route
    import trap_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int BKPT_CODE = 3
) (
    input  logic            trap,
    input  logic [XLEN-1:0] cause,
    input  priv_e           priv,
    input  logic [XLEN-1:0] medeleg,
    input  logic [XLEN-1:0] mideleg,
    input  logic [3:0]      ebreak_en,
    input  logic [2:0]      dbg_cause,
    output dest_e           dest
);

    localparam int              IDXW   = $clog2(XLEN);
    localparam logic [XLEN-1:0] LIMIT  = XLEN[XLEN-1:0];
    localparam logic [XLEN-1:0] BKPT_W = BKPT_CODE[XLEN-1:0];

    logic            is_irq;
    logic [XLEN-1:0] idx;
    logic [XLEN-1:0] mask;
    logic            deleg_bit;
    logic            is_bkpt;

    // Strip the interrupt flag and select the matching delegation mask
    always_comb begin
        is_irq    = cause[XLEN-1];
        idx       = {1'b0, cause[XLEN-2:0]};
        mask      = is_irq ? mideleg : medeleg;
        deleg_bit = (idx < LIMIT) && mask[idx[IDXW-1:0]];
        is_bkpt   = (cause == BKPT_W);
    end

    // Priority: breakpoint to debug, in-debug redirect, S, then M
    always_comb begin
        dest = DEST_NONE;
        if (trap) begin
            if (is_bkpt && ebreak_en[priv])
                dest = DEST_DBG_ENTER;
            else if (dbg_cause != 3'd0)
                dest = DEST_DBG_REDIR;
            else if ((priv == PRV_U || priv == PRV_S) && deleg_bit)
                dest = DEST_SUP;
            else
                dest = DEST_MACH;
        end
    end

endmodule

// File: rtl/trap_status_next.sv
// Builds the status word written on supervisor or machine entry.
// Combinational; assumes the bit layout held in trap_pkg.
module trap_status_next
    import trap_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] status,
    input  priv_e           priv,
    input  logic            to_sup,
    output logic [XLEN-1:0] status_next
);

    logic prev_en;

    // Enable bit of the privilege being left, then stack it
    always_comb begin
        prev_en     = status[priv];
        status_next = status;
        if (to_sup) begin
            status_next[ST_SPIE] = prev_en;
            status_next[ST_SPP]  = priv[0];
            status_next[ST_SIE]  = 1'b0;
        end else begin
            status_next[ST_MPIE]             = prev_en;
            status_next[ST_MPP_HI:ST_MPP_LO] = priv;
            status_next[ST_MIE]              = 1'b0;
        end
    end

endmodule

// File: rtl/trap_commit.sv
// Trap commit unit: registers all updates a trap needs one edge after the
// request. Holds no architectural state; the caller applies the strobes.
// Assumes at most one trap request per cycle.
module trap_commit
    import trap_pkg::*;
#(
    parameter int              XLEN         = 32,
    parameter int              BKPT_CODE    = 3,
    parameter logic [XLEN-1:0] DBG_ROM_ADDR = 'h800,
    parameter logic [XLEN-1:0] DBG_EXC_ADDR = 'h808
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_trap,
    input  logic [XLEN-1:0] i_cause,
    input  logic [XLEN-1:0] i_epc,
    input  logic [XLEN-1:0] i_bad,
    input  logic            i_bad_vld,
    input  logic [1:0]      i_priv,
    input  logic [XLEN-1:0] i_status,
    input  logic [XLEN-1:0] i_medeleg,
    input  logic [XLEN-1:0] i_mideleg,
    input  logic [XLEN-1:0] i_stvec,
    input  logic [XLEN-1:0] i_mtvec,
    input  logic [2:0]      i_dbg_cause,
    input  logic [3:0]      i_ebreak_en,
    output logic            o_pc_we,
    output logic [XLEN-1:0] o_pc,
    output logic [XLEN-1:0] o_cause,
    output logic [XLEN-1:0] o_epc,
    output logic [XLEN-1:0] o_bad,
    output logic            o_s_we,
    output logic            o_s_bad_we,
    output logic            o_m_we,
    output logic            o_m_bad_we,
    output logic            o_status_we,
    output logic [XLEN-1:0] o_status,
    output logic            o_priv_we,
    output logic [1:0]      o_priv,
    output logic            o_dbg_we,
    output logic [2:0]      o_dbg_cause,
    output logic [1:0]      o_dbg_prv,
    output logic            o_resv_clr
);

    priv_e           cur_priv;
    dest_e           dest;
    logic [XLEN-1:0] st_next;

    assign cur_priv = priv_e'(i_priv);

    trap_route #(
        .XLEN      (XLEN),
        .BKPT_CODE (BKPT_CODE)
    ) u_route (
        .trap      (i_trap),
        .cause     (i_cause),
        .priv      (cur_priv),
        .medeleg   (i_medeleg),
        .mideleg   (i_mideleg),
        .ebreak_en (i_ebreak_en),
        .dbg_cause (i_dbg_cause),
        .dest      (dest)
    );

    trap_status_next #(
        .XLEN (XLEN)
    ) u_status (
        .status      (i_status),
        .priv        (cur_priv),
        .to_sup      (dest == DEST_SUP),
        .status_next (st_next)
    );

    // Register the chosen destination's updates as one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_pc_we     <= 1'b0;
            o_pc        <= '0;
            o_cause     <= '0;
            o_epc       <= '0;
            o_bad       <= '0;
            o_s_we      <= 1'b0;
            o_s_bad_we  <= 1'b0;
            o_m_we      <= 1'b0;
            o_m_bad_we  <= 1'b0;
            o_status_we <= 1'b0;
            o_status    <= '0;
            o_priv_we   <= 1'b0;
            o_priv      <= PRV_M;
            o_dbg_we    <= 1'b0;
            o_dbg_cause <= '0;
            o_dbg_prv   <= '0;
            o_resv_clr  <= 1'b0;
        end else begin
            o_pc_we     <= 1'b0;
            o_s_we      <= 1'b0;
            o_s_bad_we  <= 1'b0;
            o_m_we      <= 1'b0;
            o_m_bad_we  <= 1'b0;
            o_status_we <= 1'b0;
            o_priv_we   <= 1'b0;
            o_dbg_we    <= 1'b0;
            o_resv_clr  <= 1'b0;
            unique case (dest)
                DEST_DBG_ENTER: begin
                    o_pc_we     <= 1'b1;
                    o_pc        <= DBG_ROM_ADDR;
                    o_epc       <= i_epc;
                    o_dbg_we    <= 1'b1;
                    o_dbg_cause <= DBG_CAUSE_SWBP;
                    o_dbg_prv   <= i_priv;
                    o_priv_we   <= 1'b1;
                    o_priv      <= legal_priv(PRV_M);
                end
                DEST_DBG_REDIR: begin
                    o_pc_we <= 1'b1;
                    o_pc    <= DBG_EXC_ADDR;
                end
                DEST_SUP: begin
                    o_pc_we     <= 1'b1;
                    o_pc        <= i_stvec;
                    o_cause     <= i_cause;
                    o_epc       <= i_epc;
                    o_bad       <= i_bad;
                    o_s_we      <= 1'b1;
                    o_s_bad_we  <= i_bad_vld;
                    o_status_we <= 1'b1;
                    o_status    <= st_next;
                    o_priv_we   <= 1'b1;
                    o_priv      <= legal_priv(PRV_S);
                    o_resv_clr  <= 1'b1;
                end
                DEST_MACH: begin
                    o_pc_we     <= 1'b1;
                    o_pc        <= i_mtvec;
                    o_cause     <= i_cause;
                    o_epc       <= i_epc;
                    o_bad       <= i_bad;
                    o_m_we      <= 1'b1;
                    o_m_bad_we  <= i_bad_vld;
                    o_status_we <= 1'b1;
                    o_status    <= st_next;
                    o_priv_we   <= 1'b1;
                    o_priv      <= legal_priv(PRV_M);
                    o_resv_clr  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R12: a request always yields a PC load on the next edge, and only then
    p_pc_follows_trap_r12: assert property (@(posedge clk) disable iff (!rst_n)
        i_trap |=> o_pc_we);
    p_no_spurious_pc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !i_trap |=> !o_pc_we);
    // R1/R7/R9: one destination at a time
    p_one_dest_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_s_we, o_m_we, o_dbg_we}));
    // R10: reservation clear only with a supervisor or machine entry
    p_resv_with_entry_r10: assert property (@(posedge clk) disable iff (!rst_n)
        o_resv_clr |-> (o_s_we || o_m_we));
    // R7: faulting address strobe never without its cause strobe
    p_sbad_needs_s_r7: assert property (@(posedge clk) disable iff (!rst_n)
        o_s_bad_we |-> o_s_we);
    // R6: supervisor entry only from user or supervisor privilege
    p_sup_from_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        o_s_we |-> ($past(i_priv) <= 2'd1));
    // R9: machine entry lands in machine privilege with MIE clear
    p_mach_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        o_m_we |-> (o_priv_we && o_priv == 2'd3 && !o_status[3]));
    // R3: redirect writes nothing but the PC
    p_redir_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (o_pc_we && o_pc == DBG_EXC_ADDR && !o_dbg_we) |-> !o_status_we);

endmodule

// File: tb/tb_trap_commit.sv
`timescale 1ns/1ps
module tb_trap_commit;

    localparam int XLEN = 32;
    localparam logic [31:0] ROM = 32'h800;
    localparam logic [31:0] EXC = 32'h808;
    localparam logic [31:0] STV = 32'h0000_4000;
    localparam logic [31:0] MTV = 32'h0000_8000;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            i_trap;
    logic [31:0]     i_cause, i_epc, i_bad, i_status, i_medeleg, i_mideleg;
    logic [31:0]     i_stvec, i_mtvec;
    logic            i_bad_vld;
    logic [1:0]      i_priv;
    logic [2:0]      i_dbg_cause;
    logic [3:0]      i_ebreak_en;
    logic            o_pc_we, o_s_we, o_s_bad_we, o_m_we, o_m_bad_we;
    logic            o_status_we, o_priv_we, o_dbg_we, o_resv_clr;
    logic [31:0]     o_pc, o_cause, o_epc, o_bad, o_status;
    logic [1:0]      o_priv, o_dbg_prv;
    logic [2:0]      o_dbg_cause;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    trap_commit #(.XLEN(XLEN)) dut (
        .clk(clk), .rst_n(rst_n), .i_trap(i_trap), .i_cause(i_cause),
        .i_epc(i_epc), .i_bad(i_bad), .i_bad_vld(i_bad_vld), .i_priv(i_priv),
        .i_status(i_status), .i_medeleg(i_medeleg), .i_mideleg(i_mideleg),
        .i_stvec(i_stvec), .i_mtvec(i_mtvec), .i_dbg_cause(i_dbg_cause),
        .i_ebreak_en(i_ebreak_en), .o_pc_we(o_pc_we), .o_pc(o_pc),
        .o_cause(o_cause), .o_epc(o_epc), .o_bad(o_bad), .o_s_we(o_s_we),
        .o_s_bad_we(o_s_bad_we), .o_m_we(o_m_we), .o_m_bad_we(o_m_bad_we),
        .o_status_we(o_status_we), .o_status(o_status), .o_priv_we(o_priv_we),
        .o_priv(o_priv), .o_dbg_we(o_dbg_we), .o_dbg_cause(o_dbg_cause),
        .o_dbg_prv(o_dbg_prv), .o_resv_clr(o_resv_clr)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] st_exp(input logic [31:0] s, input logic [1:0] p, input bit sup);
        logic [31:0] r = s;
        if (sup) begin r[5] = s[p]; r[8] = p[0]; r[1] = 1'b0; end
        else begin r[7] = s[p]; r[12:11] = p; r[3] = 1'b0; end
        return r;
    endfunction

    task automatic setup(input logic [31:0] cause, input logic [1:0] prv,
                         input logic [31:0] st, input logic bv);
        i_cause = cause; i_priv = prv; i_status = st; i_bad_vld = bv;
        i_epc = 32'h1000 + cause[7:0]; i_bad = 32'hBAD0_0000 | cause;
    endtask

    // Present one request for one cycle; return at the next falling edge
    task automatic fire();
        i_trap = 1'b1;
        @(negedge clk);
        i_trap = 1'b0;
    endtask

    task automatic t_reset();
        chk("R11 pc_we", o_pc_we, 0);
        chk("R11 strobes", {o_s_we, o_s_bad_we, o_m_we, o_m_bad_we, o_status_we,
            o_priv_we, o_dbg_we, o_resv_clr}, 0);
    endtask

    task automatic t_dbg_entry();
        setup(32'd3, 2'd1, 32'h2, 1'b0); i_ebreak_en = 4'b0010; i_dbg_cause = 0;
        fire();
        chk("R1 dbg_we", o_dbg_we, 1);
        chk("R1 dbg_cause", o_dbg_cause, 1);
        chk("R1 dbg_prv", o_dbg_prv, 1);
        chk("R1 dpc", o_epc, 32'h1003);
        chk("R1 pc", o_pc, ROM);
        chk("R1 priv", {o_priv_we, o_priv}, 3'b111);
        chk("R1 quiet", {o_status_we, o_s_we, o_m_we, o_resv_clr}, 0);
        @(negedge clk);
        chk("R12 pulse ends", {o_pc_we, o_dbg_we, o_priv_we}, 0);
    endtask

    task automatic t_bkpt_other_off();
        setup(32'd3, 2'd0, 32'h1, 1'b0); i_ebreak_en = 4'b1110; i_dbg_cause = 0;
        i_medeleg = 0;
        fire();
        chk("R2 not debug", o_dbg_we, 0);
        chk("R2 machine", o_m_we, 1);
        chk("R2 pc", o_pc, MTV);
        chk("R10 resv", o_resv_clr, 1);
    endtask

    task automatic t_redirect();
        setup(32'd5, 2'd3, 32'h8, 1'b1); i_ebreak_en = 4'b1111; i_dbg_cause = 3'd1;
        fire();
        chk("R3 pc", {31'd0, o_pc_we}, 1);
        chk("R3 pc val", o_pc, EXC);
        chk("R3 quiet", {o_s_we, o_s_bad_we, o_m_we, o_m_bad_we, o_status_we,
            o_priv_we, o_dbg_we, o_resv_clr}, 0);
    endtask

    task automatic t_bkpt_in_debug();
        setup(32'd3, 2'd3, 32'h8, 1'b0); i_ebreak_en = 4'b1000; i_dbg_cause = 3'd2;
        fire();
        chk("R4 dbg_we", o_dbg_we, 1);
        chk("R4 pc", o_pc, ROM);
        i_dbg_cause = 0;
    endtask

    task automatic t_sup_exc();
        setup(32'd13, 2'd0, 32'h0040_0001, 1'b1); i_ebreak_en = 0; i_dbg_cause = 0;
        i_medeleg = 32'h0000_2000; i_mideleg = 0;
        fire();
        chk("R6 sup", {o_s_we, o_m_we}, 2'b10);
        chk("R7 pc", o_pc, STV);
        chk("R7 cause", o_cause, 32'd13);
        chk("R7 epc", o_epc, 32'h100D);
        chk("R7 bad", {o_s_bad_we, o_m_bad_we}, 2'b10);
        chk("R7 bad val", o_bad, 32'hBAD0_000D);
        chk("R8 status", o_status, st_exp(32'h0040_0001, 2'd0, 1));
        chk("R8 priv", {o_status_we, o_priv_we, o_priv}, 4'b1101);
        chk("R10 resv", o_resv_clr, 1);
    endtask

    task automatic t_sup_irq();
        setup(32'h8000_0005, 2'd1, 32'h2, 1'b0);
        i_medeleg = 0; i_mideleg = 32'h20;
        fire();
        chk("R5 irq via mideleg", o_s_we, 1);
        chk("R7 no bad", o_s_bad_we, 0);
        chk("R8 status", o_status, st_exp(32'h2, 2'd1, 1));
        // same code as exception must consult medeleg, which is clear
        setup(32'd5, 2'd1, 32'h2, 1'b0);
        fire();
        chk("R5 exc via medeleg", {o_s_we, o_m_we}, 2'b01);
    endtask

    task automatic t_mach_from_m();
        setup(32'd13, 2'd3, 32'h8, 1'b0); i_medeleg = 32'hFFFF_FFFF;
        fire();
        chk("R6 from M", {o_s_we, o_m_we}, 2'b01);
        chk("R9 pc", o_pc, MTV);
        chk("R9 no bad", o_m_bad_we, 0);
        chk("R9 status", o_status, st_exp(32'h8, 2'd3, 0));
        chk("R9 priv", {o_priv_we, o_priv}, 3'b111);
    endtask

    task automatic t_range();
        setup(32'd40, 2'd0, 32'h1, 1'b1); i_medeleg = 32'hFFFF_FFFF;
        fire();
        chk("R6 index range", {o_s_we, o_m_we}, 2'b01);
        chk("R9 bad", {o_m_bad_we, o_bad}, {1'b1, 32'hBAD0_0028});
        chk("R9 status", o_status, st_exp(32'h1, 2'd0, 0));
        @(negedge clk);
        chk("R12 pulse ends", {o_m_we, o_resv_clr, o_status_we}, 0);
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst_n = 0; i_trap = 0; i_stvec = STV; i_mtvec = MTV;
        i_medeleg = 0; i_mideleg = 0; i_ebreak_en = 0; i_dbg_cause = 0;
        setup(32'd0, 2'd3, 32'h0, 1'b0);
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_dbg_entry();
        t_bkpt_other_off();
        t_redirect();
        t_bkpt_in_debug();
        t_sup_exc();
        t_sup_irq();
        t_mach_from_m();
        t_range();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule